// File: doc/BRIEF.md
# Zero-Crossing Gated Gain Update

This block sits in the sample path of one audio channel, either the capture side or the playback side. On the capture side it watches the converter input samples. On the playback side it watches the samples headed for the output converter. Software writes a new gain word, which may also carry a mute encoding. The block does not apply that word straight away: it keeps it as pending, and moves it into the active gain only when a watched sample has a magnitude at or below a programmable threshold. Because the switch happens close to zero, an abrupt gain step does not produce an audible click.

If no sample comes near zero, the pending word is forced into effect after a fixed number of sample strobes. Turning mute on and turning it off follow exactly the same path as any other gain change. Each channel has its own instance and its own threshold input.

Top module: `zc_gain_gate`

## Requirements
- R1: On synchronous reset, `gain_o` equals the parameter `RESET_GAIN` (default 8'h40) and `pending_o` is 0.
- R2: A write (`req_wr_i`=1) of a word that differs from `gain_o` sets `pending_o` to 1 on the next clock edge and leaves `gain_o` unchanged. Any word value, including a mute encoding, is handled this way.
- R3: While the block is pending, a strobed sample with |sample| <= `thresh_i` loads the pending word into `gain_o` and clears `pending_o`, both on the clock edge that samples the strobe.
- R4: A strobed sample with |sample| > `thresh_i` leaves `gain_o` unchanged, for positive and negative samples alike. The most-negative code is given magnitude 2^(SAMPLE_W-1)-1. With 16-bit samples, -32768 counts as within a threshold of 32767 but not within a threshold of 32766.
- R5: If no strobed sample qualifies, the pending word is applied on the edge that samples the `TIMEOUT`-th strobe (default 64) after the write. Before that strobe, the block stays pending.
- R6: A write while the block is pending replaces the pending word and restarts the strobe count from zero.
- R7: A write of a word equal to `gain_o` clears `pending_o` on the next edge and leaves `gain_o` unchanged. Any earlier pending word is dropped.
- R8: When a write and a sample strobe fall in the same cycle, the write takes effect. That sample is neither evaluated against the threshold nor counted toward the timeout.
- R9: While `smp_vld_i` is 0, the sample value has no effect on `gain_o`, `pending_o` or the timeout count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_i | input | SAMPLE_W | Signed watched sample (two's complement) |
| smp_vld_i | input | 1 | Sample strobe, one per sample period |
| thresh_i | input | SAMPLE_W-1 | Unsigned near-zero threshold |
| req_gain_i | input | GAIN_W | Requested gain/mute word |
| req_wr_i | input | 1 | Write strobe for the requested word |
| gain_o | output | GAIN_W | Gain/mute word in effect (registered) |
| pending_o | output | 1 | A requested change is waiting (registered) |

## Verification
On every cycle, the assertions check four things. The active gain moves only on a strobed sample with no colliding write. A differing write always leaves the block pending. An equal write cancels the pending state without moving the gain. The block never stays pending past the timeout number of strobes. Some behaviours can only be shown by the bench's scenarios, because they depend on the exact value that lands: which word is applied, the saturating magnitude at the most-negative code, the exact strobe on which the timeout fires, the restart of the count on replacement, and the priority rule on a same-cycle collision.

// File: rtl/zc_pkg.sv
package zc_pkg;
  typedef enum logic [1:0] {
    ZC_IDLE    = 2'd0,
    ZC_WAIT    = 2'd1
  } zc_state_e;

  function automatic int unsigned zc_cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/zc_mag_cmp.sv
module zc_mag_cmp #(
  parameter int SAMPLE_W = 16
) (
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic        [SAMPLE_W-2:0] thresh_i,
  output logic                       near_o
);
  localparam logic [SAMPLE_W-1:0] MIN_CODE = {1'b1, {(SAMPLE_W-1){1'b0}}};
  localparam logic [SAMPLE_W-2:0] MAX_MAG  = {(SAMPLE_W-1){1'b1}};

  logic [SAMPLE_W-1:0] neg_val;
  logic [SAMPLE_W-2:0] mag;

  always_comb begin
    neg_val = -smp_i;
    if (!smp_i[SAMPLE_W-1])
      mag = smp_i[SAMPLE_W-2:0];
    else if (smp_i == MIN_CODE)
      mag = MAX_MAG;
    else
      mag = neg_val[SAMPLE_W-2:0];
    near_o = (mag <= thresh_i);
  end
endmodule

// File: rtl/zc_timeout_ctr.sv
module zc_timeout_ctr #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic step_i,
  output logic expire_o
);
  localparam int CW = zc_pkg::zc_cnt_w(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear_i)
      cnt <= '0;
    else if (step_i)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign expire_o = step_i && (cnt == LAST);
endmodule

// File: rtl/zc_gain_gate.sv
module zc_gain_gate #(
  parameter int                SAMPLE_W   = 16,
  parameter int                GAIN_W     = 8,
  parameter int                TIMEOUT    = 64,
  parameter logic [GAIN_W-1:0] RESET_GAIN = 8'h40
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic signed [SAMPLE_W-1:0] smp_i,
  input  logic                       smp_vld_i,
  input  logic        [SAMPLE_W-2:0] thresh_i,
  input  logic        [GAIN_W-1:0]   req_gain_i,
  input  logic                       req_wr_i,
  output logic        [GAIN_W-1:0]   gain_o,
  output logic                       pending_o
);
  import zc_pkg::*;

  zc_state_e         state;
  logic [GAIN_W-1:0] pend_q;
  logic              near;
  logic              eval;
  logic              step;
  logic              expire;
  logic              apply;

  zc_mag_cmp #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .smp_i    (smp_i),
    .thresh_i (thresh_i),
    .near_o   (near)
  );

  // a strobed sample is only evaluated when no write collides with it
  assign eval  = (state == ZC_WAIT) && smp_vld_i && !req_wr_i;
  assign step  = eval && !near;
  assign apply = eval && (near || expire);

  zc_timeout_ctr #(.LIMIT(TIMEOUT)) u_tmo (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (req_wr_i),
    .step_i   (step),
    .expire_o (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ZC_IDLE;
      pend_q <= RESET_GAIN;
      gain_o <= RESET_GAIN;
    end else if (req_wr_i) begin
      if (req_gain_i == gain_o) begin
        state <= ZC_IDLE;
      end else begin
        state  <= ZC_WAIT;
        pend_q <= req_gain_i;
      end
    end else if (apply) begin
      gain_o <= pend_q;
      state  <= ZC_IDLE;
    end
  end

  assign pending_o = (state == ZC_WAIT);
endmodule

// File: rtl/zc_gain_gate_chk.sv
module zc_gain_gate_chk #(
  parameter int                SAMPLE_W   = 16,
  parameter int                GAIN_W     = 8,
  parameter int                TIMEOUT    = 64,
  parameter logic [GAIN_W-1:0] RESET_GAIN = 8'h40
) (
  input logic                clk,
  input logic                rst,
  input logic                smp_vld_i,
  input logic [GAIN_W-1:0]   req_gain_i,
  input logic                req_wr_i,
  input logic [GAIN_W-1:0]   gain_o,
  input logic                pending_o
);
  localparam int CW = zc_pkg::zc_cnt_w(TIMEOUT);

  logic [CW:0] seen;
  logic        rst_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst || req_wr_i)
      seen <= '0;
    else if (pending_o && smp_vld_i)
      seen <= seen + 1'b1;
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_q && !rst)
      reset_state_chk: assert (gain_o == RESET_GAIN && !pending_o);
  end

  // R3
  gain_move_cause_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(gain_o) |-> $past(pending_o && smp_vld_i && !req_wr_i));

  // R2
  diff_write_pends_chk: assert property (@(posedge clk) disable iff (rst)
    (req_wr_i && req_gain_i != gain_o) |=> (pending_o && $stable(gain_o)));

  // R7
  equal_write_cancels_chk: assert property (@(posedge clk) disable iff (rst)
    (req_wr_i && req_gain_i == gain_o) |=> (!pending_o && $stable(gain_o)));

  // R5
  timeout_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pending_o |-> (seen < TIMEOUT));

  // R9
  idle_strobe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!smp_vld_i && !req_wr_i) |=> ($stable(gain_o) && $stable(pending_o)));
endmodule

bind zc_gain_gate zc_gain_gate_chk #(
  .SAMPLE_W(SAMPLE_W), .GAIN_W(GAIN_W), .TIMEOUT(TIMEOUT), .RESET_GAIN(RESET_GAIN)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .smp_vld_i  (smp_vld_i),
  .req_gain_i (req_gain_i),
  .req_wr_i   (req_wr_i),
  .gain_o     (gain_o),
  .pending_o  (pending_o)
);

// File: tb/tb_zc_gain_gate.sv
module tb_zc_gain_gate;
  logic               clk = 0;
  logic               rst = 1;
  logic signed [15:0] smp = '0;
  logic               vld = 0;
  logic [14:0]        thr = 15'd100;
  logic [7:0]         req = '0;
  logic               wr  = 0;
  logic [7:0]         gain;
  logic               pend;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  zc_gain_gate dut (
    .clk(clk), .rst(rst), .smp_i(smp), .smp_vld_i(vld), .thresh_i(thr),
    .req_gain_i(req), .req_wr_i(wr), .gain_o(gain), .pending_o(pend)
  );

  task automatic check(input string tag, input logic [7:0] g_exp, input logic p_exp);
    total++;
    if (gain !== g_exp || pend !== p_exp) begin
      bad++;
      $display("FAIL %s: gain=%h pend=%b expected gain=%h pend=%b", tag, gain, pend, g_exp, p_exp);
    end
  endtask

  task automatic wr_gain(input logic [7:0] v);
    @(negedge clk); req = v; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic send(input logic signed [15:0] s);
    @(negedge clk); smp = s; vld = 1;
    @(negedge clk); vld = 0;
  endtask

  task automatic t_reset;
    check("R1 reset", 8'h40, 1'b0);
  endtask

  task automatic t_zero_apply;
    thr = 15'd100;
    wr_gain(8'h20);
    check("R2 pend after write", 8'h40, 1'b1);
    send(16'sd500);
    check("R4 positive outside", 8'h40, 1'b1);
    send(-16'sd500);
    check("R4 negative outside", 8'h40, 1'b1);
    send(-16'sd100);
    check("R3 apply at threshold", 8'h20, 1'b0);
  endtask

  task automatic t_no_strobe;
    wr_gain(8'h30);
    @(negedge clk); smp = '0;
    repeat (5) @(negedge clk);
    check("R9 no strobe no change", 8'h20, 1'b1);
    send(16'sd0);
    check("R3 apply on zero", 8'h30, 1'b0);
  endtask

  task automatic t_timeout;
    wr_gain(8'h91);
    for (int i = 0; i < 63; i++) send(16'sd1000);
    check("R5 still pending at 63", 8'h30, 1'b1);
    send(16'sd1000);
    check("R5 forced at 64", 8'h91, 1'b0);
  endtask

  task automatic t_replace;
    wr_gain(8'h22);
    for (int i = 0; i < 40; i++) send(-16'sd2000);
    wr_gain(8'h23);
    for (int i = 0; i < 63; i++) send(-16'sd2000);
    check("R6 count restarted", 8'h91, 1'b1);
    send(-16'sd2000);
    check("R6 replaced word applied", 8'h23, 1'b0);
  endtask

  task automatic t_equal;
    wr_gain(8'h55);
    check("R2 pend 55", 8'h23, 1'b1);
    wr_gain(8'h23);
    check("R7 equal write cancels", 8'h23, 1'b0);
    send(16'sd0);
    check("R7 dropped word stays out", 8'h23, 1'b0);
  endtask

  task automatic t_priority;
    wr_gain(8'h66);
    @(negedge clk); req = 8'h77; wr = 1; smp = '0; vld = 1;
    @(negedge clk); wr = 0; vld = 0;
    check("R8 write wins over sample", 8'h23, 1'b1);
    for (int i = 0; i < 63; i++) send(16'sd3000);
    check("R8 collided sample not counted", 8'h23, 1'b1);
    send(16'sd3000);
    check("R8 applied after full count", 8'h77, 1'b0);
  endtask

  task automatic t_saturate;
    thr = 15'h7FFF;
    wr_gain(8'h80);
    send(-16'sd32768);
    check("R4 min code within max thr", 8'h80, 1'b0);
    thr = 15'h7FFE;
    wr_gain(8'h02);
    send(-16'sd32768);
    check("R4 min code outside 32766", 8'h80, 1'b1);
    send(16'sd32766);
    check("R3 apply at 32766", 8'h02, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_zero_apply();
    t_no_strobe();
    t_timeout();
    t_replace();
    t_equal();
    t_priority();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule